// File: doc/BRIEF.md
# Receive Descriptor Dispatch Classifier

This block sits in front of a receive reorder engine. Each transaction carries one eight-word (256-bit) receive descriptor. The block reads a few routing flags and fields from it and produces one dispatch decision. The decision names the exit ring index, a route class, and two enables that tell the downstream engine whether to run reorder processing and whether to run a packet-number check. It also raises a protocol-error flag when a descriptor breaks the field-validity rules.

Destination codes below seven name an exit ring directly. Higher codes pass through a small remap table held in registers and written through a narrow configuration port. Fragments bypass reordering and go to a ring given on a static input. A frameless block-ack request carries only a small set of fields, and any other nonzero bit sends it to an error ring, which is also a static input. Decisions leave through a one-deep registered valid/ready stage, and the input side stalls while that stage is held.

Descriptor word w occupies bits [32w+31:32w] of `in_desc`. The bit positions used are these. Word 2 holds the sequence number [19:8], the fragment flag [20], the block-ack-request flag [23] and the PN-valid flag [24]. Word 3 holds the peer metadata. Word 4 holds the queue address low bits. Word 5 holds the queue address high bits [7:0], the destination code [26:22] and the frameless flag [27]. Word 6 holds the push reason [1:0]. Route class encoding: 0 = normal, 1 = bypass, 2 = block-ack request, 3 = error.

Top module: `rx_desc_dispatch`

## Requirements
- R1: A descriptor with the fragment, request and frameless flags clear and destination code 0 to 6 gets ring equal to the code, class 0 and reorder enable 1.
- R2: Codes 7 to 31 take their ring from remap entry [code]. Every entry reads ring 0 after reset. A configuration write with address 7 to 31 updates that entry from the next cycle. A write to address 0 to 6 changes nothing.
- R3: A set fragment flag (word 2 bit 20) gives class 1 and ring `frag_ring`, with both enables 0. This overrides the request flag and the destination code.
- R4: For class 0 the PN-check enable equals the PN-valid flag (word 2 bit 24). For every other class it is 0.
- R5: A set request flag (word 2 bit 23) without the fragment flag gives class 2, with the ring mapped from the destination code as in R1/R2, reorder enable 1 and PN-check enable 0.
- R6: A frameless descriptor (word 5 bit 27) is treated as in R5 when its nonzero bits lie only in word 3, word 4, word 5 [7:0], word 5 bit 27, word 2 [19:8] and word 2 bit 23.
- R7: A frameless descriptor with any other bit set gives class 3, ring `err_ring`, protocol error 1 and both enables 0. This overrides R3.
- R8: A push reason of 3 (word 6 [1:0]) sets the protocol-error flag and leaves ring, class and enables as the other rules give them. Reasons 0 to 2 have no effect on the decision.
- R9: `in_ready` is high when the output stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all decision outputs hold. Each accepted descriptor yields exactly one decision, in order, one cycle after acceptance.
- R10: During reset `out_valid` is 0, and it is still 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted this cycle when high with in_valid |
| in_desc | input | 256 | Eight 32-bit descriptor words, word 0 in the low bits |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Downstream takes the decision |
| out_ring | output | 3 | Exit ring index |
| out_class | output | 2 | Route class |
| out_reorder_en | output | 1 | Run reorder processing |
| out_pn_en | output | 1 | Run packet-number check |
| out_proto_err | output | 1 | Field-validity violation seen |
| cfg_we | input | 1 | Remap table write strobe |
| cfg_addr | input | 5 | Remap entry (destination code) |
| cfg_data | input | 3 | Ring written to the entry |
| frag_ring | input | 3 | Ring for fragments |
| err_ring | input | 3 | Ring for rejected frameless descriptors |

## Verification
The checker assumes that `frag_ring` and `err_ring` stay static while decisions are in flight, and that a configuration write landing in the acceptance cycle is not relied on by either side. The stimulus sets both rings once before reset ends and does table writes only while no descriptor is offered. It sweeps every destination code against every combination of fragment, request and PN-valid flags, places a single bit in each of the 256 positions of a frameless descriptor, and holds the output stalled with a second descriptor waiting.

// File: rtl/rxdd_pkg.sv
// Shared constants and types for the receive descriptor dispatch classifier.
// Assumes descriptor word w sits at bits [32w+31:32w] of the flat bus.
package rxdd_pkg;
    parameter int WORD_W       = 32;
    parameter int DESC_WORDS   = 8;
    parameter int DESC_W       = WORD_W * DESC_WORDS;
    parameter int CODE_W       = 5;
    parameter int RING_W       = 3;
    parameter int DIRECT_CODES = 7;
    parameter int NUM_CODES    = 1 << CODE_W;

    // Word indices of the fields the classifier reads
    localparam int W_FLAGS  = 2;
    localparam int W_PEER   = 3;
    localparam int W_QLO    = 4;
    localparam int W_ROUTE  = 5;
    localparam int W_REASON = 6;

    // Absolute bit positions on the flat bus
    localparam int FRAG_BIT  = W_FLAGS * WORD_W + 20;
    localparam int BAR_BIT   = W_FLAGS * WORD_W + 23;
    localparam int PNV_BIT   = W_FLAGS * WORD_W + 24;
    localparam int SEQ_LO    = W_FLAGS * WORD_W + 8;
    localparam int SEQ_W     = 12;
    localparam int CODE_LO   = W_ROUTE * WORD_W + 22;
    localparam int FBAR_BIT  = W_ROUTE * WORD_W + 27;
    localparam int QHI_LO    = W_ROUTE * WORD_W;
    localparam int QHI_W     = 8;
    localparam int REASON_LO = W_REASON * WORD_W;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_BYPASS = 2'd1,
        CLS_BAR    = 2'd2,
        CLS_ERROR  = 2'd3
    } route_cls_e;

    typedef struct packed {
        logic [RING_W-1:0] ring;
        route_cls_e        cls;
        logic              reorder_en;
        logic              pn_en;
        logic              proto_err;
    } decision_t;

    // Bits a frameless request may carry; everything else must be zero
    function automatic logic [DESC_W-1:0] fbar_allowed_mask();
        logic [DESC_W-1:0] m;
        m = '0;
        for (int b = 0; b < WORD_W; b++) begin
            m[W_PEER * WORD_W + b] = 1'b1;
            m[W_QLO  * WORD_W + b] = 1'b1;
        end
        for (int b = 0; b < QHI_W; b++) m[QHI_LO + b] = 1'b1;
        for (int b = 0; b < SEQ_W; b++) m[SEQ_LO + b] = 1'b1;
        m[FBAR_BIT] = 1'b1;
        m[BAR_BIT]  = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rxdd_remap.sv
// Remap table for high destination codes.
// Entries exist only for codes DIRECT_CODES..NUM_CODES-1; lower addresses
// are accepted on the write port but store nothing and read as zero.
module rxdd_remap #(
    parameter int CODE_W       = 5,
    parameter int RING_W       = 3,
    parameter int DIRECT_CODES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_addr,
    input  logic [RING_W-1:0] wr_data,
    input  logic [CODE_W-1:0] rd_code,
    output logic [RING_W-1:0] rd_ring
);
    localparam int NUM = 1 << CODE_W;

    logic [RING_W-1:0] entry [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_ent
        if (i < DIRECT_CODES) begin : g_none
            assign entry[i] = '0;
        end else begin : g_reg
            logic [RING_W-1:0] q;
            // Hold one remapped ring; reset to ring 0, load on matching write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == CODE_W'(i))
                    q <= wr_data;
            end
            assign entry[i] = q;
        end
    end

    // Combinational read of the entry selected by the descriptor's code
    always_comb rd_ring = entry[rd_code];
endmodule

// File: rtl/rxdd_decode.sv
// Combinational classifier: turns one descriptor into a dispatch decision.
// Assumes remap_ring is the table entry for the code driven on code_out.
// Precedence: frameless violation, fragment, block-ack request, normal.
module rxdd_decode
    import rxdd_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [RING_W-1:0] remap_ring,
    input  logic [RING_W-1:0] frag_ring,
    input  logic [RING_W-1:0] err_ring,
    output logic [CODE_W-1:0] code_out,
    output decision_t         dec
);
    localparam logic [DESC_W-1:0] ALLOWED = fbar_allowed_mask();

    logic              fbar, frag, bar, pnv, viol, bad_reason;
    logic [RING_W-1:0] mapped;

    // Pull the routing fields out of the descriptor
    always_comb begin
        code_out   = desc[CODE_LO +: CODE_W];
        fbar       = desc[FBAR_BIT];
        frag       = desc[FRAG_BIT];
        bar        = desc[BAR_BIT];
        pnv        = desc[PNV_BIT];
        viol       = fbar && |(desc & ~ALLOWED);
        bad_reason = desc[REASON_LO +: 2] == 2'd3;
        mapped     = (code_out < CODE_W'(DIRECT_CODES)) ? code_out[RING_W-1:0]
                                                        : remap_ring;
    end

    // Apply the routing precedence
    always_comb begin
        dec = '0;
        if (viol) begin
            dec.ring      = err_ring;
            dec.cls       = CLS_ERROR;
            dec.proto_err = 1'b1;
        end else if (frag) begin
            dec.ring      = frag_ring;
            dec.cls       = CLS_BYPASS;
            dec.proto_err = bad_reason;
        end else if (bar || fbar) begin
            dec.ring       = mapped;
            dec.cls        = CLS_BAR;
            dec.reorder_en = 1'b1;
            dec.proto_err  = bad_reason;
        end else begin
            dec.ring       = mapped;
            dec.cls        = CLS_NORMAL;
            dec.reorder_en = 1'b1;
            dec.pn_en      = pnv;
            dec.proto_err  = bad_reason;
        end
    end
endmodule

// File: rtl/rxdd_out_reg.sv
// One-deep registered valid/ready output stage.
// Assumes the upstream holds its data stable until it sees ready.
module rxdd_out_reg
    import rxdd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_valid,
    output logic      up_ready,
    input  decision_t up_dec,
    output logic      dn_valid,
    input  logic      dn_ready,
    output decision_t dn_dec
);
    // Accept whenever the stage is empty or draining this cycle
    always_comb up_ready = !dn_valid || dn_ready;

    // Load a new decision or clear the stage when it drains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_dec   <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid)
                dn_dec <= up_dec;
        end
    end
endmodule

// File: rtl/rx_desc_dispatch.sv
// Receive descriptor dispatch classifier top level.
// Classifies each accepted descriptor and registers the decision.
// Assumes frag_ring and err_ring are quasi-static configuration.
module rx_desc_dispatch
    import rxdd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DESC_W-1:0]   in_desc,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [RING_W-1:0]   out_ring,
    output logic [1:0]          out_class,
    output logic                out_reorder_en,
    output logic                out_pn_en,
    output logic                out_proto_err,
    input  logic                cfg_we,
    input  logic [CODE_W-1:0]   cfg_addr,
    input  logic [RING_W-1:0]   cfg_data,
    input  logic [RING_W-1:0]   frag_ring,
    input  logic [RING_W-1:0]   err_ring
);
    logic [CODE_W-1:0] code;
    logic [RING_W-1:0] remap_ring;
    decision_t         dec_c, dec_q;

    rxdd_remap #(
        .CODE_W       (CODE_W),
        .RING_W       (RING_W),
        .DIRECT_CODES (DIRECT_CODES)
    ) u_remap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_code (code),
        .rd_ring (remap_ring)
    );

    rxdd_decode u_decode (
        .desc       (in_desc),
        .remap_ring (remap_ring),
        .frag_ring  (frag_ring),
        .err_ring   (err_ring),
        .code_out   (code),
        .dec        (dec_c)
    );

    rxdd_out_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_dec   (dec_c),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_dec   (dec_q)
    );

    // Flatten the registered decision onto the output ports
    always_comb begin
        out_ring       = dec_q.ring;
        out_class      = dec_q.cls;
        out_reorder_en = dec_q.reorder_en;
        out_pn_en      = dec_q.pn_en;
        out_proto_err  = dec_q.proto_err;
    end
endmodule

// File: rtl/rxdd_chk.sv
// Protocol and decision-consistency checker for rx_desc_dispatch.
// Assumes frag_ring and err_ring do not change while decisions are held.
module rxdd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [2:0] out_ring,
    input logic [1:0] out_class,
    input logic       out_reorder_en,
    input logic       out_pn_en,
    input logic       out_proto_err,
    input logic [2:0] frag_ring,
    input logic [2:0] err_ring
);
    // R10: the output stage is empty in the cycle after a reset cycle
    p_reset_empty_r10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9: an empty output stage always accepts
    p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R9: an accepted descriptor shows up as a decision next cycle
    p_accept_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R9: a stalled decision holds every field
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ring)
            && $stable(out_class) && $stable(out_reorder_en)
            && $stable(out_pn_en) && $stable(out_proto_err));

    // R3: bypass decisions carry the fragment ring and no checks
    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == 2'd1 |->
            out_ring == frag_ring && !out_reorder_en && !out_pn_en);

    // R7: error decisions carry the error ring and the error flag
    p_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == 2'd3 |->
            out_ring == err_ring && out_proto_err && !out_reorder_en && !out_pn_en);

    // R4: the PN check is only requested for normal decisions
    p_pn_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pn_en |-> out_class == 2'd0);

    // R5: request decisions run reorder processing without a PN check
    p_bar_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == 2'd2 |-> out_reorder_en && !out_pn_en);
endmodule

bind rx_desc_dispatch rxdd_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_ring       (out_ring),
    .out_class      (out_class),
    .out_reorder_en (out_reorder_en),
    .out_pn_en      (out_pn_en),
    .out_proto_err  (out_proto_err),
    .frag_ring      (frag_ring),
    .err_ring       (err_ring)
);

// File: tb/rx_desc_dispatch_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps codes and flag combinations, every single-bit
// position of a frameless descriptor, push reasons and a stalled output.
module rx_desc_dispatch_bench;
    localparam int DW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_desc = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [2:0]    out_ring;
    logic [1:0]    out_class;
    logic          out_reorder_en, out_pn_en, out_proto_err;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [2:0]    cfg_data = '0;
    logic [2:0]    frag_ring = 3'd5;
    logic [2:0]    err_ring = 3'd6;

    int n_vec = 0;
    int n_bad = 0;
    logic [2:0] shadow [32];

    always #2 clk = ~clk;

    rx_desc_dispatch u_rx_desc_dispatch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .out_valid(out_valid), .out_ready(out_ready),
        .out_ring(out_ring), .out_class(out_class),
        .out_reorder_en(out_reorder_en), .out_pn_en(out_pn_en),
        .out_proto_err(out_proto_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .frag_ring(frag_ring), .err_ring(err_ring)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Bits a frameless request may carry (R6)
    function automatic bit allowed_bit(input int b);
        int w = b / 32;
        int k = b % 32;
        if (w == 3 || w == 4) return 1;
        if (w == 5 && (k < 8 || k == 27)) return 1;
        if (w == 2 && ((k >= 8 && k <= 19) || k == 23)) return 1;
        return 0;
    endfunction

    function automatic logic [2:0] map_code(input int code);
        return (code < 7) ? 3'(code) : shadow[code];
    endfunction

    // Expected {ring, class, reorder, pn, err} from the requirements
    function automatic logic [7:0] expect_dec(input logic [DW-1:0] d);
        bit fbar = d[5*32+27];
        bit viol = 0;
        bit frag = d[2*32+20];
        bit bar  = d[2*32+23];
        bit pnv  = d[2*32+24];
        int code = int'(d[5*32+22 +: 5]);
        bit perr = (d[6*32 +: 2] == 2'd3);
        if (fbar)
            for (int b = 0; b < DW; b++)
                if (d[b] && !allowed_bit(b)) viol = 1;
        if (viol)        return {err_ring, 2'd3, 1'b0, 1'b0, 1'b1};
        if (frag)        return {frag_ring, 2'd1, 1'b0, 1'b0, perr};
        if (bar || fbar) return {map_code(code), 2'd2, 1'b1, 1'b0, perr};
        return {map_code(code), 2'd0, 1'b1, pnv, perr};
    endfunction

    function automatic logic [7:0] got_dec();
        return {out_ring, out_class, out_reorder_en, out_pn_en, out_proto_err};
    endfunction

    task automatic apply(input string req, input logic [DW-1:0] d);
        @(negedge clk);
        in_desc  = d;
        in_valid = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {24'd0, out_valid, got_dec()}, {24'd0, 1'b1, expect_dec(d)});
    endtask

    task automatic cfg_write(input int a, input logic [2:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 7) shadow[a] = v;
    endtask

    function automatic logic [DW-1:0] plain_desc(input int code, input bit frag,
                                                 input bit bar, input bit pnv,
                                                 input int reason);
        logic [DW-1:0] d;
        for (int w = 0; w < 8; w++) d[w*32 +: 32] = $urandom;
        d[5*32+27]     = 1'b0;
        d[2*32+20]     = frag;
        d[2*32+23]     = bar;
        d[2*32+24]     = pnv;
        d[5*32+22 +: 5] = 5'(code);
        d[6*32 +: 2]   = 2'(reason);
        return d;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d, a_desc, b_desc;
        for (int i = 0; i < 32; i++) shadow[i] = 3'd0;
        repeat (3) @(negedge clk);
        // R10: empty output during reset
        check("R10", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {30'd0, out_valid, in_ready}, 32'd1);

        // R2: table entries read ring 0 after reset
        apply("R2", plain_desc(20, 0, 0, 1, 1));
        apply("R2", plain_desc(31, 0, 0, 0, 0));

        // R2: load remap entries, and a write below 7 that must not stick
        for (int c = 7; c < 32; c++) cfg_write(c, 3'((c * 3 + 1) % 8));
        cfg_write(4, 3'd7);
        apply("R2", plain_desc(4, 0, 0, 0, 1));

        // R1 R2 R3 R4 R5: every code against every flag combination
        for (int code = 0; code < 32; code++) begin
            for (int f = 0; f < 8; f++) begin
                string tag;
                if (f[0])      tag = "R3";
                else if (f[1]) tag = "R5";
                else if (f[2]) tag = "R4";
                else if (code < 7) tag = "R1";
                else tag = "R2";
                apply(tag, plain_desc(code, f[0], f[1], f[2], code % 3));
            end
        end

        // R8: each push reason on a normal, a bypass and a request descriptor
        for (int r = 0; r < 4; r++) begin
            apply("R8", plain_desc(9, 0, 0, 1, r));
            apply("R8", plain_desc(2, 1, 0, 0, r));
            apply("R8", plain_desc(12, 0, 1, 0, r));
        end

        // R6: frameless request with all permitted fields filled
        d = '0;
        for (int b = 0; b < DW; b++) if (allowed_bit(b)) d[b] = 1'($urandom);
        d[5*32+27] = 1'b1;
        apply("R6", d);

        // R6 R7: one extra bit in each position of a frameless request
        for (int b = 0; b < DW; b++) begin
            d = '0;
            d[5*32+27] = 1'b1;
            d[b] = 1'b1;
            apply(allowed_bit(b) ? "R6" : "R7", d);
        end

        // R9: stall the output with a second descriptor waiting
        a_desc = plain_desc(3, 0, 0, 1, 0);
        b_desc = plain_desc(15, 0, 1, 0, 0);
        @(negedge clk);
        out_ready = 1'b0;
        in_desc = a_desc; in_valid = 1'b1;
        @(negedge clk);
        in_desc = b_desc;
        check("R9", {23'd0, out_valid, got_dec()}, {23'd0, 1'b1, expect_dec(a_desc)});
        repeat (3) begin
            @(negedge clk);
            check("R9", {22'd0, in_ready, out_valid, got_dec()},
                  {22'd0, 1'b0, 1'b1, expect_dec(a_desc)});
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", {23'd0, out_valid, got_dec()}, {23'd0, 1'b1, expect_dec(b_desc)});
        @(negedge clk);
        check("R9", {31'd0, out_valid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule